// File: doc/BRIEF.md
# Sector Protection Lock Controller

This block decides, for each sector of a flash-style storage array, whether program and erase operations are allowed. Two protection layers are kept per sector. A persistent bit lives in storage that keeps its value through a hardware reset. A dynamic bit is volatile and is restored to "unprotected" by any reset. A sector may be written only when both of its bits are 1. A single global lock bit guards the persistent layer. Its value after a hardware reset, and the rules for setting it, depend on a two-bit one-time-programmable mode field.

Commands arrive as single-cycle strobes with an opcode, a sector index and a mode-bit operand. A query port takes a sector index and returns a registered "allowed" flag one cycle later. Persistent-bit operations hold a busy flag for a parameterised number of cycles, and commands offered while it is high are dropped. Password checking happens outside the block; it supplies a one-cycle unlock pulse. A power-on load input restores the non-volatile contents to their shipped state. The hardware reset input restores only the volatile state.

Top module: `sector_guard`

## Requirements
- R1: `query_ok` equals the AND of the persistent and dynamic bits of the sector placed on `query_sect` one clock earlier (1 = program/erase allowed, 0 = protected).
- R2: While `lock_bit` = 1, opcode 1 clears the persistent bit of `cmd_sect` only, and opcode 2 sets every persistent bit to 1.
- R3: While `lock_bit` = 0, opcodes 1 and 2 change no persistent bit, start no busy period, and set both `st_fail` and `st_lockerr` to 1.
- R4: Opcode 3 clears and opcode 4 sets the dynamic bit of `cmd_sect`, whatever the lock bit and the persistent bits hold. `rst` or `por` returns every dynamic bit to 1.
- R5: After `rst`, `lock_bit` is 0 when `mode_bits` = 01 and 1 otherwise. `sw_rst` clears both status flags and leaves the lock bit, mode bits, persistent bits and dynamic bits unchanged.
- R6: Opcode 5 clears `lock_bit`. When `mode_bits` is 11 or 10, only `rst` or `por` can set it back to 1.
- R7: A `pw_unlock` pulse sets `lock_bit` to 1 when `mode_bits` = 01. In the other modes it is ignored.
- R8: The mode field encodes 11 = persistent (changeable), 10 = persistent (fixed) and 01 = password (fixed). Opcode 6 clears every mode bit whose `cmd_mode` bit is 0. It aborts, setting `st_fail` and `st_lockerr` and leaving the mode unchanged, when `cmd_mode` = 00 or when `mode_bits` is not 11.
- R9: An accepted opcode 1 or 2 holds `busy` high for exactly BUSY_CYC cycles. Any command offered while `busy` is high is ignored.
- R10: `rst` leaves the persistent bits and the mode field unchanged. `por` sets all persistent bits to 1, the mode to 11 and `lock_bit` to 1.
- R11: Every command taken while not busy rewrites both status flags. A command that succeeds clears them, and opcodes 0 and 7 are no-operations that also clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| por | input | 1 | Synchronous power-on load of the non-volatile state, active high |
| sw_rst | input | 1 | Software reset: clears the status flags only |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode, encoded as listed in the requirements |
| cmd_sect | input | SECT_W | Target sector of a command |
| cmd_mode | input | 2 | Mode-program operand; a 0 bit programs that mode bit |
| pw_unlock | input | 1 | Pulse from an external password match |
| query_sect | input | SECT_W | Sector to test |
| query_ok | output | 1 | Registered program/erase permission for the queried sector |
| lock_bit | output | 1 | Global persistent-layer lock (1 = changeable) |
| mode_bits | output | 2 | Current protection mode field |
| busy | output | 1 | Persistent-bit operation in progress |
| st_fail | output | 1 | Last command failed |
| st_lockerr | output | 1 | Last failure was caused by a lock |

## Verification
The permission output is tried with the persistent bit alone cleared, the dynamic bit alone cleared, and both set, on neighbouring sectors. This shows that the two layers are ANDed and that a write reaches only its target sector. The lock bit is driven through each path that may change it: clear command, unlock pulse in both modes, hardware reset in both modes, and software reset. This separates the persistent-mode rules from the password-mode rules. Refused persistent-bit writes and aborted mode programs are checked for both unchanged state and the two status flags. The busy window is measured cycle by cycle, with a command injected inside it.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [2:0] {
    OP_NONE       = 3'd0,
    OP_PPB_PROG   = 3'd1,
    OP_PPB_ERASE  = 3'd2,
    OP_DYB_PROT   = 3'd3,
    OP_DYB_UNPROT = 3'd4,
    OP_LOCK_CLR   = 3'd5,
    OP_MODE_PROG  = 3'd6,
    OP_RSVD       = 3'd7
  } sg_op_e;

  localparam logic [1:0] MODE_PERSIST_TMP  = 2'b11;
  localparam logic [1:0] MODE_PERSIST_LOCK = 2'b10;
  localparam logic [1:0] MODE_PASSWORD     = 2'b01;
endpackage

// File: rtl/sg_ppb_array.sv
module sg_ppb_array #(
  parameter int NUM_SECT = 16,
  parameter int BUSY_CYC = 8,
  localparam int SECT_W  = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1,
  localparam int CNT_W   = $clog2(BUSY_CYC + 1)
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rst,
  input  logic              prog_req,
  input  logic              erase_req,
  input  logic              lock_i,
  input  logic [SECT_W-1:0] sect_i,
  input  logic [SECT_W-1:0] rd_sect_i,
  output logic              rd_bit_o,
  output logic              busy_o,
  output logic              refused_o
);
  logic [NUM_SECT-1:0] ppb_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                go_prog, go_erase;

  assign refused_o = (prog_req | erase_req) & ~lock_i;
  assign go_prog   = prog_req & lock_i;
  assign go_erase  = erase_req & lock_i;
  assign busy_o    = (cnt_q != '0);
  assign rd_bit_o  = ppb_q[rd_sect_i];

  // Non-volatile contents: only the power-on load touches them besides commands.
  always_ff @(posedge clk) begin
    if (por) begin
      ppb_q <= '1;
    end else if (!rst) begin
      if (go_erase)
        ppb_q <= '1;
      else if (go_prog)
        ppb_q[sect_i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (por || rst)
      cnt_q <= '0;
    else if (go_prog || go_erase)
      cnt_q <= CNT_W'(BUSY_CYC);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  // R3
  ppb_locked_chk: assert property (@(posedge clk) disable iff (por)
    (!lock_i) |=> $stable(ppb_q));

  // R9
  busy_count_chk: assert property (@(posedge clk) disable iff (por || rst)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sg_dyb_array.sv
module sg_dyb_array #(
  parameter int NUM_SECT = 16,
  localparam int SECT_W  = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rst,
  input  logic              prot_req,
  input  logic              unprot_req,
  input  logic [SECT_W-1:0] sect_i,
  input  logic [SECT_W-1:0] rd_sect_i,
  output logic              rd_bit_o
);
  logic [NUM_SECT-1:0] dyb_q;

  assign rd_bit_o = dyb_q[rd_sect_i];

  always_ff @(posedge clk) begin
    if (por || rst)
      dyb_q <= '1;
    else if (prot_req)
      dyb_q[sect_i] <= 1'b0;
    else if (unprot_req)
      dyb_q[sect_i] <= 1'b1;
  end

  // R4
  dyb_reset_chk: assert property (@(posedge clk) disable iff (por)
    rst |=> (dyb_q == '1));
endmodule

// File: rtl/sg_lock_ctrl.sv
module sg_lock_ctrl
  import sg_pkg::*;
(
  input  logic       clk,
  input  logic       por,
  input  logic       rst,
  input  logic       sw_rst,
  input  logic       take_i,
  input  sg_op_e     op_i,
  input  logic [1:0] cmd_mode_i,
  input  logic       pw_unlock_i,
  input  logic       ppb_refused_i,
  output logic       lock_o,
  output logic [1:0] mode_o,
  output logic       st_fail_o,
  output logic       st_lockerr_o
);
  logic       lock_q;
  logic [1:0] mode_q;
  logic       fail_q, lockerr_q;
  logic       mode_req, mode_abort, cmd_bad;

  assign mode_req   = take_i && (op_i == OP_MODE_PROG);
  assign mode_abort = mode_req && ((cmd_mode_i == 2'b00) || (mode_q != MODE_PERSIST_TMP));
  assign cmd_bad    = mode_abort | ppb_refused_i;

  always_ff @(posedge clk) begin
    if (por) begin
      mode_q    <= MODE_PERSIST_TMP;
      lock_q    <= 1'b1;
      fail_q    <= 1'b0;
      lockerr_q <= 1'b0;
    end else if (rst) begin
      lock_q    <= (mode_q != MODE_PASSWORD);
      fail_q    <= 1'b0;
      lockerr_q <= 1'b0;
    end else begin
      if (take_i && (op_i == OP_LOCK_CLR))
        lock_q <= 1'b0;
      else if (pw_unlock_i && (mode_q == MODE_PASSWORD))
        lock_q <= 1'b1;

      if (mode_req && !mode_abort)
        mode_q <= mode_q & cmd_mode_i;

      if (sw_rst) begin
        fail_q    <= 1'b0;
        lockerr_q <= 1'b0;
      end else if (take_i) begin
        fail_q    <= cmd_bad;
        lockerr_q <= cmd_bad;
      end
    end
  end

  assign lock_o       = lock_q;
  assign mode_o       = mode_q;
  assign st_fail_o    = fail_q;
  assign st_lockerr_o = lockerr_q;

  // R6
  lock_stays_low_chk: assert property (@(posedge clk) disable iff (por || rst)
    (mode_q != MODE_PASSWORD && !lock_q) |=> !lock_q);

  // R8
  mode_legal_chk: assert property (@(posedge clk) disable iff (por)
    mode_q != 2'b00);

  // R8
  mode_frozen_chk: assert property (@(posedge clk) disable iff (por)
    (mode_q != MODE_PERSIST_TMP) |=> $stable(mode_q));
endmodule

// File: rtl/sector_guard.sv
module sector_guard
  import sg_pkg::*;
#(
  parameter int NUM_SECT = 16,
  parameter int BUSY_CYC = 8,
  localparam int SECT_W  = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              sw_rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [SECT_W-1:0] cmd_sect,
  input  logic [1:0]        cmd_mode,
  input  logic              pw_unlock,
  input  logic [SECT_W-1:0] query_sect,
  output logic              query_ok,
  output logic              lock_bit,
  output logic [1:0]        mode_bits,
  output logic              busy,
  output logic              st_fail,
  output logic              st_lockerr
);
  sg_op_e op;
  logic   take, ppb_rd, dyb_rd, refused, lock_w;
  logic   ok_q;

  assign op   = sg_op_e'(cmd_op);
  assign take = cmd_valid && !busy && !rst && !por;

  sg_ppb_array #(.NUM_SECT(NUM_SECT), .BUSY_CYC(BUSY_CYC)) u_ppb (
    .clk       (clk),
    .por       (por),
    .rst       (rst),
    .prog_req  (take && (op == OP_PPB_PROG)),
    .erase_req (take && (op == OP_PPB_ERASE)),
    .lock_i    (lock_w),
    .sect_i    (cmd_sect),
    .rd_sect_i (query_sect),
    .rd_bit_o  (ppb_rd),
    .busy_o    (busy),
    .refused_o (refused)
  );

  sg_dyb_array #(.NUM_SECT(NUM_SECT)) u_dyb (
    .clk        (clk),
    .por        (por),
    .rst        (rst),
    .prot_req   (take && (op == OP_DYB_PROT)),
    .unprot_req (take && (op == OP_DYB_UNPROT)),
    .sect_i     (cmd_sect),
    .rd_sect_i  (query_sect),
    .rd_bit_o   (dyb_rd)
  );

  sg_lock_ctrl u_lock (
    .clk           (clk),
    .por           (por),
    .rst           (rst),
    .sw_rst        (sw_rst),
    .take_i        (take),
    .op_i          (op),
    .cmd_mode_i    (cmd_mode),
    .pw_unlock_i   (pw_unlock),
    .ppb_refused_i (refused),
    .lock_o        (lock_w),
    .mode_o        (mode_bits),
    .st_fail_o     (st_fail),
    .st_lockerr_o  (st_lockerr)
  );

  always_ff @(posedge clk) begin
    if (por || rst)
      ok_q <= 1'b0;
    else
      ok_q <= ppb_rd & dyb_rd;
  end

  assign query_ok = ok_q;
  assign lock_bit = lock_w;
endmodule

// File: tb/sector_guard_bench.sv
module sector_guard_bench;
  localparam int NS  = 16;
  localparam int BC  = 8;
  localparam int SW  = $clog2(NS);

  logic          clk = 1'b0;
  logic          rst = 1'b1, por = 1'b1, sw_rst = 1'b0;
  logic          cmd_valid = 1'b0, pw_unlock = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [SW-1:0] cmd_sect = '0, query_sect = '0;
  logic [1:0]    cmd_mode = 2'b11;
  logic          query_ok, lock_bit, busy, st_fail, st_lockerr;
  logic [1:0]    mode_bits;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sector_guard #(.NUM_SECT(NS), .BUSY_CYC(BC)) u_sector_guard (
    .clk, .rst, .por, .sw_rst, .cmd_valid, .cmd_op, .cmd_sect, .cmd_mode,
    .pw_unlock, .query_sect, .query_ok, .lock_bit, .mode_bits, .busy,
    .st_fail, .st_lockerr
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmd(logic [2:0] op, int s, logic [1:0] m);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sect = SW'(s); cmd_mode = m;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic qchk(int s, int exp, string req);
    @(negedge clk);
    query_sect = SW'(s);
    @(negedge clk);
    chk(req, int'(query_ok), exp);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic pulse_unlock();
    @(negedge clk); pw_unlock = 1'b1;
    @(negedge clk); pw_unlock = 1'b0;
  endtask

  task automatic do_rst();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 por mode", int'(mode_bits), 3);
    chk("R10 por lock", int'(lock_bit), 1);
    chk("R9 idle after reset", int'(busy), 0);
    chk("R11 status after reset", int'({st_fail, st_lockerr}), 0);
    for (int s = 0; s < NS; s++) qchk(s, 1, "R1 all open after reset");
  endtask

  task automatic t_ppb();
    int n;
    cmd(3'd1, 3, 2'b11);
    chk("R9 busy after prog", int'(busy), 1);
    cmd_valid = 1'b1; cmd_op = 3'd3; cmd_sect = SW'(5);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
    wait_idle();
    qchk(5, 1, "R9 command during busy ignored");
    qchk(3, 0, "R2 programmed sector protected");
    qchk(2, 1, "R2 neighbour below untouched");
    qchk(4, 1, "R2 neighbour above untouched");
    chk("R11 prog success status", int'({st_fail, st_lockerr}), 0);
    cmd(3'd1, 9, 2'b11);
    wait_idle();
    cmd(3'd2, 0, 2'b11);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R9 busy length", n, BC);
    qchk(3, 1, "R2 erase all reopens 3");
    qchk(9, 1, "R2 erase all reopens 9");
  endtask

  task automatic t_dyb();
    cmd(3'd3, 7, 2'b11);
    qchk(7, 0, "R4 dyb protect");
    qchk(6, 1, "R4 dyb neighbour");
    cmd(3'd5, 0, 2'b11);
    chk("R6 lock clear", int'(lock_bit), 0);
    cmd(3'd4, 7, 2'b11);
    qchk(7, 1, "R4 dyb unprotect with lock low");
    cmd(3'd3, 9, 2'b11);
    qchk(9, 0, "R4 dyb protect with lock low");
    chk("R4 dyb status clean", int'(st_fail), 0);
  endtask

  task automatic t_refuse();
    cmd(3'd1, 1, 2'b11);
    chk("R3 refused fail flag", int'(st_fail), 1);
    chk("R3 refused lock flag", int'(st_lockerr), 1);
    chk("R3 refused no busy", int'(busy), 0);
    qchk(1, 1, "R3 refused prog no change");
    cmd(3'd0, 0, 2'b11);
    chk("R11 noop clears status", int'({st_fail, st_lockerr}), 0);
    cmd(3'd2, 0, 2'b11);
    chk("R3 refused erase flag", int'(st_fail), 1);
    qchk(9, 0, "R3 refused erase keeps dyb");
    @(negedge clk); sw_rst = 1'b1;
    @(negedge clk); sw_rst = 1'b0;
    chk("R5 sw_rst clears status", int'({st_fail, st_lockerr}), 0);
    chk("R5 sw_rst keeps lock", int'(lock_bit), 0);
    qchk(9, 0, "R5 sw_rst keeps dyb");
    pulse_unlock();
    chk("R7 unlock ignored in persistent", int'(lock_bit), 0);
    do_rst();
    chk("R5 rst sets lock in persistent", int'(lock_bit), 1);
    qchk(9, 1, "R4 rst reopens dyb");
    cmd(3'd1, 4, 2'b11);
    wait_idle();
    do_rst();
    qchk(4, 0, "R10 ppb survives rst");
  endtask

  task automatic t_mode();
    cmd(3'd6, 0, 2'b00);
    chk("R8 both bits aborts", int'({st_fail, st_lockerr}), 3);
    chk("R8 both bits mode kept", int'(mode_bits), 3);
    cmd(3'd6, 0, 2'b01);
    chk("R8 password program", int'(mode_bits), 1);
    chk("R11 mode success status", int'(st_fail), 0);
    chk("R5 lock unchanged by mode prog", int'(lock_bit), 1);
    cmd(3'd6, 0, 2'b10);
    chk("R8 second program aborts", int'(st_fail), 1);
    chk("R8 frozen mode kept", int'(mode_bits), 1);
    do_rst();
    chk("R5 rst clears lock in password", int'(lock_bit), 0);
    chk("R10 mode survives rst", int'(mode_bits), 1);
    pulse_unlock();
    chk("R7 unlock in password", int'(lock_bit), 1);
    cmd(3'd5, 0, 2'b11);
    chk("R6 clear in password", int'(lock_bit), 0);
    @(negedge clk); por = 1'b1;
    @(negedge clk); por = 1'b0;
    chk("R10 por mode restore", int'(mode_bits), 3);
    chk("R10 por lock", int'(lock_bit), 1);
    qchk(4, 1, "R10 por erases ppb");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por = 1'b0; rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ppb();
    t_dyb();
    t_refuse();
    t_mode();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule